// File: doc/BRIEF.md
# Clock-Presence Power and Mute Sequencer

This block is the control state machine for a line-output converter. Its power state follows only the presence of the master clock, the presence of the bit clock and an active-low mute pin. Its outputs are an enable for the negative-rail pump, an enable for the output stage, and an unsigned gain word that the datapath multiplies into the samples. The clock-detection logic is upstream, so presence and data activity reach the block as synchronous flags. A once-per-sample strobe advances the gain when the output is being muted.

There are four states. `Off` has everything down. `Standby` has the pump running while the output is silent. `Enable` is normal playback at full gain. `Draining` is the quiet exit from `Enable`: the output stage stays powered until the gain has reached zero.

The fall to zero depends on whether audio was flowing at the moment of the mute. With data flowing, the gain falls in equal steps over `RAMP_LEN` sample strobes. With no data, the gain is held and then cut to zero in one step on the `HARD_DELAY`-th strobe. Unmuting restores full gain at once.

The named transitions are:

| Transition | Condition |
|---|---|
| Off→Standby | mute asserted |
| Off→Enable | bit clock present and unmuted |
| Standby→Enable | bit clock present and unmuted |
| Enable→Draining | mute asserted or bit clock lost |
| Draining→Standby | gain has reached zero |
| Draining→Enable | bit clock present and unmuted |
| any→Off | master clock lost |

Top module: `pwr_mute_seq`

## Requirements
- R1: While reset is asserted and after it is released with the master clock absent, `pwr_state` is 0, `gain` is 0, and both enables are low.
- R2: `pwr_state` encodes Off=0, Standby=1, Enable=2, Draining=3. `pump_en` is high in every state except Off. `stage_en` is high only in Enable and Draining.
- R3: In Off with the master clock present, if `mute_n`=1 and the bit clock is present, the state is Enable with `gain`=`RAMP_LEN*GAIN_STEP` one cycle later. If `mute_n`=1 and the bit clock is absent, the state stays Off.
- R4: In Off with the master clock present and `mute_n`=0, the state is Standby one cycle later whatever the bit clock does, and `gain` is 0.
- R5: Standby is held while `mute_n`=0 or the bit clock is absent. The bit clock may stop in Standby without any change.
- R6: In Enable, `mute_n`=0 or a lost bit clock moves the state to Draining on the next cycle, with the gain still at full scale.
- R7: A master clock that is absent moves any state to Off on the next cycle, with `gain`=0.
- R8: If `data_active` was 1 when Draining was entered, each `sample_tick` lowers `gain` by `GAIN_STEP`, saturating at 0. Cycles without a strobe leave `gain` unchanged, so `gain` reaches 0 on the `RAMP_LEN`-th strobe.
- R9: If `data_active` was 0 when Draining was entered, `gain` stays at full scale for `HARD_DELAY-1` strobes and becomes 0 on the `HARD_DELAY`-th strobe.
- R10: Draining moves to Standby on the cycle after `gain` reads 0, and never while `gain` is nonzero.
- R11: From Standby or Draining, `mute_n`=1 together with a present bit clock gives Enable with full-scale `gain` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk_present | input | 1 | Master clock detected |
| bclk_present | input | 1 | Bit clock detected |
| mute_n | input | 1 | Mute pin, 0 = mute requested |
| data_active | input | 1 | Nonzero audio currently flowing |
| sample_tick | input | 1 | One-cycle strobe per audio sample |
| pwr_state | output | 2 | Current power state code |
| pump_en | output | 1 | Negative-rail pump enable |
| stage_en | output | 1 | Output stage enable |
| gain | output | GAIN_W | Unsigned gain, full scale = RAMP_LEN*GAIN_STEP |

## Verification
The bench builds the block with `RAMP_LEN`=10, `GAIN_STEP`=100, `HARD_DELAY`=4 and `GAIN_W`=16, so full scale is 1000. A ten-strobe ramp lets every intermediate gain value be checked one at a time, including the last nonzero value of 100 and the cycle on which Standby follows zero. The short delay exposes the boundary between the third and fourth strobe in the no-data case. It also makes room to interrupt a partly finished ramp, both by unmuting and by removing the master clock.

// File: rtl/pms_pkg.sv
package pms_pkg;
    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_STBY  = 2'd1,
        PS_ENA   = 2'd2,
        PS_DRAIN = 2'd3
    } pwr_st_t;
endpackage

// File: rtl/pms_fsm.sv
module pms_fsm
    import pms_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    mclk_present,
    input  logic    bclk_present,
    input  logic    mute_n,
    input  logic    gain_zero,
    output pwr_st_t state,
    output pwr_st_t nxt
);
    logic play_req;

    // Playback is wanted when the pin is unmuted and the bit clock runs.
    assign play_req = mute_n && bclk_present;

    // Next-state decode: loss of the master clock wins over everything.
    always_comb begin
        nxt = state;
        if (!mclk_present) begin
            nxt = PS_OFF;
        end else begin
            unique case (state)
                PS_OFF: begin
                    if (!mute_n)           nxt = PS_STBY;
                    else if (bclk_present) nxt = PS_ENA;
                    else                   nxt = PS_OFF;
                end
                PS_STBY: begin
                    if (play_req) nxt = PS_ENA;
                end
                PS_ENA: begin
                    if (!play_req) nxt = PS_DRAIN;
                end
                PS_DRAIN: begin
                    if (play_req)       nxt = PS_ENA;
                    else if (gain_zero) nxt = PS_STBY;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_OFF;
        else        state <= nxt;
    end
endmodule

// File: rtl/pms_gain.sv
module pms_gain
    import pms_pkg::*;
#(
    parameter int GAIN_W     = 16,
    parameter int RAMP_LEN   = 944,
    parameter int GAIN_STEP  = 64,
    parameter int HARD_DELAY = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  pwr_st_t           state,
    input  pwr_st_t           nxt,
    input  logic              data_active,
    input  logic              sample_tick,
    output logic [GAIN_W-1:0] gain
);
    localparam logic [GAIN_W-1:0] FULL_G = GAIN_W'(RAMP_LEN * GAIN_STEP);
    localparam logic [GAIN_W-1:0] STEP_G = GAIN_W'(GAIN_STEP);
    localparam int                CNT_W  = $clog2(HARD_DELAY + 1);
    localparam logic [CNT_W-1:0]  LAST_C = CNT_W'(HARD_DELAY - 1);

    logic             soft_q;  // data was flowing when the mute began
    logic [CNT_W-1:0] hold_cnt;

    // The gain register follows the next state, so it changes on the same
    // edge as the state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain     <= '0;
            soft_q   <= 1'b0;
            hold_cnt <= '0;
        end else begin
            unique case (nxt)
                PS_ENA: begin
                    gain     <= FULL_G;
                    hold_cnt <= '0;
                end
                PS_OFF, PS_STBY: begin
                    gain     <= '0;
                    hold_cnt <= '0;
                end
                PS_DRAIN: begin
                    if (state != PS_DRAIN) begin
                        // Entering the drain: choose ramp or delayed cut.
                        soft_q   <= data_active;
                        hold_cnt <= '0;
                    end else if (sample_tick) begin
                        if (soft_q) begin
                            gain <= (gain < STEP_G) ? '0 : gain - STEP_G;
                        end else if (hold_cnt == LAST_C) begin
                            gain <= '0;
                        end else begin
                            hold_cnt <= hold_cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pwr_mute_seq.sv
module pwr_mute_seq
    import pms_pkg::*;
#(
    parameter int GAIN_W     = 16,
    parameter int RAMP_LEN   = 944,
    parameter int GAIN_STEP  = 64,
    parameter int HARD_DELAY = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mclk_present,
    input  logic              bclk_present,
    input  logic              mute_n,
    input  logic              data_active,
    input  logic              sample_tick,
    output logic [1:0]        pwr_state,
    output logic              pump_en,
    output logic              stage_en,
    output logic [GAIN_W-1:0] gain
);
    pwr_st_t state;
    pwr_st_t nxt;
    logic    gain_zero;

    assign gain_zero = (gain == '0);

    pms_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mclk_present (mclk_present),
        .bclk_present (bclk_present),
        .mute_n       (mute_n),
        .gain_zero    (gain_zero),
        .state        (state),
        .nxt          (nxt)
    );

    pms_gain #(
        .GAIN_W     (GAIN_W),
        .RAMP_LEN   (RAMP_LEN),
        .GAIN_STEP  (GAIN_STEP),
        .HARD_DELAY (HARD_DELAY)
    ) u_gain (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .nxt         (nxt),
        .data_active (data_active),
        .sample_tick (sample_tick),
        .gain        (gain)
    );

    // Output decode from the registered state.
    always_comb begin
        pwr_state = state;
        unique case (state)
            PS_OFF:   begin pump_en = 1'b0; stage_en = 1'b0; end
            PS_STBY:  begin pump_en = 1'b1; stage_en = 1'b0; end
            PS_ENA:   begin pump_en = 1'b1; stage_en = 1'b1; end
            PS_DRAIN: begin pump_en = 1'b1; stage_en = 1'b1; end
        endcase
    end
endmodule

// File: rtl/pwr_mute_seq_chk.sv
module pwr_mute_seq_chk #(
    parameter int GAIN_W     = 16,
    parameter int RAMP_LEN   = 944,
    parameter int GAIN_STEP  = 64,
    parameter int HARD_DELAY = 4
)(
    input logic              clk,
    input logic              rst_n,
    input logic              mclk_present,
    input logic              bclk_present,
    input logic              mute_n,
    input logic [1:0]        pwr_state,
    input logic              pump_en,
    input logic              stage_en,
    input logic [GAIN_W-1:0] gain
);
    localparam logic [GAIN_W-1:0] FULL_G = GAIN_W'(RAMP_LEN * GAIN_STEP);

    p_stage_needs_pump_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stage_en |-> pump_en);

    p_clock_loss_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mclk_present |=> (pwr_state == 2'd0 && gain == '0));

    p_enable_to_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mclk_present && pwr_state == 2'd2 && (!mute_n || !bclk_present))
        |=> pwr_state == 2'd3);

    p_gain_nonrising_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd3) |=> (pwr_state != 2'd3 || gain <= $past(gain)));

    p_drain_waits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd3 && gain != '0 && mclk_present && !(mute_n && bclk_present))
        |=> pwr_state == 2'd3);

    p_unmute_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mclk_present && mute_n && bclk_present)
        |=> (pwr_state == 2'd2 && gain == FULL_G));
endmodule

bind pwr_mute_seq pwr_mute_seq_chk #(
    .GAIN_W     (GAIN_W),
    .RAMP_LEN   (RAMP_LEN),
    .GAIN_STEP  (GAIN_STEP),
    .HARD_DELAY (HARD_DELAY)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mclk_present (mclk_present),
    .bclk_present (bclk_present),
    .mute_n       (mute_n),
    .pwr_state    (pwr_state),
    .pump_en      (pump_en),
    .stage_en     (stage_en),
    .gain         (gain)
);

// File: tb/pwr_mute_seq_tb_top.sv
module pwr_mute_seq_tb_top;
    localparam int GW   = 16;
    localparam int RL   = 10;
    localparam int GS   = 100;
    localparam int HD   = 4;
    localparam int FULL = RL * GS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mclk_present = 1'b0;
    logic          bclk_present = 1'b0;
    logic          mute_n = 1'b0;
    logic          data_active = 1'b0;
    logic          sample_tick = 1'b0;
    logic [1:0]    pwr_state;
    logic          pump_en;
    logic          stage_en;
    logic [GW-1:0] gain;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    typedef struct {
        string req;
        int    st;
        int    g;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;

    always #4 clk = ~clk;

    pwr_mute_seq #(
        .GAIN_W (GW), .RAMP_LEN (RL), .GAIN_STEP (GS), .HARD_DELAY (HD)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mclk_present (mclk_present),
        .bclk_present (bclk_present),
        .mute_n       (mute_n),
        .data_active  (data_active),
        .sample_tick  (sample_tick),
        .pwr_state    (pwr_state),
        .pump_en      (pump_en),
        .stage_en     (stage_en),
        .gain         (gain)
    );

    // Monitor: pops expected items and compares them with the outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                bit   ep, es;
                e  = exp_q.pop_front();
                ep = (e.st != 0);
                es = (e.st == 2 || e.st == 3);
                checks++;
                if (int'(pwr_state) != e.st || int'(gain) != e.g ||
                    pump_en != ep || stage_en != es) begin
                    errors++;
                    $display("FAIL %s: state=%0d gain=%0d pump=%0b stage=%0b, expected state=%0d gain=%0d pump=%0b stage=%0b",
                             e.req, pwr_state, gain, pump_en, stage_en, e.st, e.g, ep, es);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string req, input int st, input int g);
        exp_t e;
        e.req = req; e.st = st; e.g = g;
        exp_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    task automatic tick();
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        expect_out("R1 in reset", 0, 0);
        rst_n = 1'b1;
        cyc(2);
        expect_out("R1 after reset, no master clock", 0, 0);

        mclk_present = 1'b1; mute_n = 1'b1; bclk_present = 1'b0;
        cyc(3);
        expect_out("R3 Off holds without bit clock", 0, 0);
        bclk_present = 1'b1;
        cyc(1);
        expect_out("R3 Off to Enable, R2 enables", 2, FULL);

        mclk_present = 1'b0;
        cyc(1);
        expect_out("R7 Enable to Off on clock loss", 0, 0);

        mclk_present = 1'b1; mute_n = 1'b0;
        cyc(1);
        expect_out("R4 Off to Standby when muted", 1, 0);
        bclk_present = 1'b0;
        cyc(3);
        expect_out("R5 Standby holds with bit clock stopped", 1, 0);
        mute_n = 1'b1;
        cyc(2);
        expect_out("R5 Standby holds unmuted without bit clock", 1, 0);
        bclk_present = 1'b1;
        cyc(1);
        expect_out("R11 Standby to Enable full gain", 2, FULL);

        data_active = 1'b1; mute_n = 1'b0;
        cyc(1);
        expect_out("R6 Enable to Draining on mute", 3, FULL);
        cyc(3);
        expect_out("R8 gain still without strobe", 3, FULL);
        for (int i = 1; i <= RL - 1; i++) begin
            tick();
            expect_out("R8 soft ramp step", 3, FULL - GS * i);
        end
        tick();
        expect_out("R10 gain zero, still Draining", 3, 0);
        cyc(1);
        expect_out("R10 Draining to Standby", 1, 0);

        data_active = 1'b0; mute_n = 1'b1;
        cyc(1);
        expect_out("R11 unmute from Standby", 2, FULL);
        bclk_present = 1'b0;
        cyc(1);
        expect_out("R6 Enable to Draining on bit clock loss", 3, FULL);
        for (int i = 1; i <= HD - 1; i++) begin
            tick();
            expect_out("R9 gain held before delayed cut", 3, FULL);
        end
        tick();
        expect_out("R9 delayed single-step cut", 3, 0);
        cyc(1);
        expect_out("R10 Standby after cut", 1, 0);

        bclk_present = 1'b1;
        cyc(1);
        expect_out("R11 bit clock restart re-enables", 2, FULL);
        data_active = 1'b1; mute_n = 1'b0;
        cyc(1);
        tick();
        tick();
        expect_out("R8 two ramp steps", 3, FULL - 2 * GS);
        mute_n = 1'b1;
        cyc(1);
        expect_out("R11 unmute during Draining", 2, FULL);

        mute_n = 1'b0;
        cyc(1);
        tick();
        expect_out("R8 ramp step after re-mute", 3, FULL - GS);
        mclk_present = 1'b0;
        cyc(1);
        expect_out("R7 Draining to Off on clock loss", 0, 0);

        cyc(2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule